// File: doc/BRIEF.md
# Offset-Encoded Frontplane Transfer Counter

This block counts the words that cross the peripheral side of a parallel port and stops the peripheral handshake once a programmed number of words has passed. The count is kept in offset form: the value 0x00FFFF stands for "no transfers left". To ask for N word transfers the host loads N + 0x00FFFF. For a request given in bytes while the port runs in 16-bit mode, N is half the byte count. Any stored value at or below 0x00FFFF counts as zero.

The host loads the counter in two steps. First it writes a 16-bit low holding register and an 8-bit upper holding register. Then it raises a load control bit, and the rising edge copies both holding registers into the working counter. While the counter is enabled, each transfer pulse lowers the count by one. When the count reaches its zero code, the block asserts a frontplane-disable output and a sticky zero flag. The zero flag is meant for the interrupt logic outside this block.

The host can read back either half of the working counter to work out the residue. A handshake-pending status output tells the host whether the last counted word still has its handshake open, so the residue can be corrected by one.

Top module: `xfer_countdown`

## Requirements
- R1: After reset the working count is 0x00FFFF, the holding registers are zero, and zeroFlag and hsPending are low. A read at rdAddr 0 returns 0xFFFF and a read at rdAddr 1 returns 0x0000.
- R2: A write with wrAddr 0 stores wrData[15:0] in the low holding register. A write with wrAddr 1 stores wrData[7:0] in the upper holding register. Neither write changes the working count.
- R3: A 0-to-1 transition of loadCtl copies {upper, low} holding registers into the working count at the next clock edge. Holding loadCtl high loads nothing more.
- R4: While cntEn is high and the count is above 0x00FFFF, each cycle with xferStrobe high lowers the count by exactly one.
- R5: The count never goes below its zero code. At or below 0x00FFFF, transfer pulses leave it unchanged, and fpDisable equals cntEn AND (count <= 0x00FFFF).
- R6: While cntEn is low, transfer pulses do not change the count and fpDisable stays low.
- R7: zeroFlag rises when a decrement lands on 0x00FFFF, and also when a value at or below 0x00FFFF is loaded. It stays high until a value above 0x00FFFF is loaded or cntClr is applied.
- R8: cntClr sets the count to 0x00FFFF and clears zeroFlag and hsPending. It takes priority over a load edge and over a transfer in the same cycle.
- R9: A transfer pulse that arrives while fpDisable is low sets hsPending. hsDone clears hsPending. If both occur in the same cycle, hsPending is set.
- R10: rdData returns count[15:0] when rdAddr is 0, and count[23:16] zero-extended to 16 bits when rdAddr is 1. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Holding register write strobe |
| wrAddr | input | 1 | 0 selects the low holding register, 1 selects the upper holding register |
| wrData | input | 16 | Write data |
| loadCtl | input | 1 | Load control bit; a rising edge loads the counter |
| cntEn | input | 1 | Counter enable |
| cntClr | input | 1 | Counter reset bit |
| xferStrobe | input | 1 | One pulse per word crossing the peripheral side |
| hsDone | input | 1 | Handshake of the last word completed |
| rdAddr | input | 1 | Read select: 0 for low half, 1 for upper byte |
| rdData | output | 16 | Read data for the selected counter half |
| fpDisable | output | 1 | Blocks further peripheral handshakes |
| zeroFlag | output | 1 | Sticky count-reached-zero flag |
| hsPending | output | 1 | Handshake of a counted word still open |

## Verification
The bench goes after the borrow from 0x010000 down to 0x00FFFF. A design that decrements only the low half would read 0x01FFFF there and never raise the flag. It drives strobes held at the zero code, where a missing floor would wrap the count to 0x00FFFE or 0xFFFFFF. It holds loadCtl high while the holding registers change, which catches a design that loads on the level instead of the edge. It also fires cntClr together with a load edge, and hsDone together with a transfer, to expose a wrong priority order. Loads of values at or below the zero code test that the flag is set on load and not only on a decrement.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;   // counter reset bit active
    logic load;    // copy holding registers into counter
    logic dec;     // count one transfer
    logic hsSet;   // accepted transfer opens a handshake
    logic hsClr;   // handshake completed
  } xfcStrobe_t;

endpackage

// File: rtl/xfc_ctrl.sv
module xfc_ctrl
  import xfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntEn,
  input  logic       cntClr,
  input  logic       loadCtl,
  input  logic       xferStrobe,
  input  logic       hsDone,
  input  logic       atZero,
  output xfcStrobe_t stb,
  output logic       fpDisable
);

  logic loadCtlQ;
  logic loadEdge;

  always_ff @(posedge clk) begin
    if (!rstN) loadCtlQ <= 1'b0;
    else       loadCtlQ <= loadCtl;
  end

  assign loadEdge  = loadCtl & ~loadCtlQ;
  assign fpDisable = cntEn & atZero;

  // Priority: clear, then load, then decrement
  always_comb begin
    stb.clear = cntClr;
    stb.load  = loadEdge & ~cntClr;
    stb.dec   = cntEn & xferStrobe & ~atZero & ~loadEdge & ~cntClr;
    stb.hsSet = xferStrobe & ~fpDisable & ~cntClr;
    stb.hsClr = hsDone & ~cntClr;
  end

  // R6: a disabled counter is never told to count
  assert_no_count_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |-> !stb.dec);

  // R5: a blocked frontplane never produces a decrement
  assert_no_count_when_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    fpDisable |-> !stb.dec);

  // R3: a load edge cannot repeat on the next cycle
  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> !stb.load);

  // R8: clear suppresses every other strobe
  assert_clear_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |-> !(stb.load || stb.dec || stb.hsSet || stb.hsClr));

endmodule

// File: rtl/xfc_datapath.sv
module xfc_datapath
  import xfc_pkg::*;
#(
  parameter int                 CNT_W     = 24,
  parameter int                 LO_W      = 16,
  parameter logic [CNT_W-1:0]   ZERO_CODE = 24'h00FFFF
) (
  input  logic            clk,
  input  logic            rstN,
  input  xfcStrobe_t      stb,
  input  logic            wrEn,
  input  logic            wrAddr,
  input  logic [LO_W-1:0] wrData,
  input  logic            rdAddr,
  output logic [LO_W-1:0] rdData,
  output logic            atZero,
  output logic            zeroFlag,
  output logic            hsPending
);

  localparam int               HI_W      = CNT_W - LO_W;
  localparam logic [CNT_W-1:0] LAST_STEP = ZERO_CODE + CNT_W'(1);

  logic [LO_W-1:0]  holdLo;
  logic [HI_W-1:0]  holdHi;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] loadVal;
  logic [LO_W-1:0]  rdHi;

  assign loadVal = {holdHi, holdLo};
  assign atZero  = (count <= ZERO_CODE);

  // Holding registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLo <= '0;
      holdHi <= '0;
    end else if (wrEn) begin
      if (!wrAddr) holdLo <= wrData;
      else         holdHi <= wrData[HI_W-1:0];
    end
  end

  // Working counter, zero flag, handshake-pending flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= ZERO_CODE;
      zeroFlag  <= 1'b0;
      hsPending <= 1'b0;
    end else if (stb.clear) begin
      count     <= ZERO_CODE;
      zeroFlag  <= 1'b0;
      hsPending <= 1'b0;
    end else begin
      if (stb.load) begin
        count    <= loadVal;
        zeroFlag <= (loadVal <= ZERO_CODE);
      end else if (stb.dec) begin
        count <= count - CNT_W'(1);
        if (count == LAST_STEP) zeroFlag <= 1'b1;
      end
      if (stb.hsSet)      hsPending <= 1'b1;
      else if (stb.hsClr) hsPending <= 1'b0;
    end
  end

  // Upper byte read path, padded when narrower than the bus
  generate
    if (HI_W < LO_W) begin : g_padHi
      assign rdHi = {{(LO_W-HI_W){1'b0}}, count[CNT_W-1:LO_W]};
    end else begin : g_fullHi
      assign rdHi = count[CNT_W-1:LO_W];
    end
  endgenerate

  assign rdData = rdAddr ? rdHi : count[LO_W-1:0];

  // R4: each counted transfer removes exactly one
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |=> count == $past(count) - CNT_W'(1));

  // R5: nothing moves the count once it sits at or below zero
  assert_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (atZero && !stb.load && !stb.clear) |=> $stable(count));

  // R3: a load takes the holding value from before any same-cycle write
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> count == $past(loadVal));

  // R7: the zero flag is sticky
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (zeroFlag && !stb.load && !stb.clear) |=> zeroFlag);

  // R8: clear returns count and flags to their idle values
  assert_clear_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (count == ZERO_CODE && !zeroFlag && !hsPending));

  // R9: an accepted transfer leaves the handshake open
  assert_pending_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.hsSet && !stb.clear) |=> hsPending);

endmodule

// File: rtl/xfer_countdown.sv
module xfer_countdown
  import xfc_pkg::*;
#(
  parameter int               CNT_W     = 24,
  parameter int               LO_W      = 16,
  parameter logic [CNT_W-1:0] ZERO_CODE = 24'h00FFFF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            wrAddr,
  input  logic [LO_W-1:0] wrData,
  input  logic            loadCtl,
  input  logic            cntEn,
  input  logic            cntClr,
  input  logic            xferStrobe,
  input  logic            hsDone,
  input  logic            rdAddr,
  output logic [LO_W-1:0] rdData,
  output logic            fpDisable,
  output logic            zeroFlag,
  output logic            hsPending
);

  xfcStrobe_t stb;
  logic       atZero;

  xfc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEn      (cntEn),
    .cntClr     (cntClr),
    .loadCtl    (loadCtl),
    .xferStrobe (xferStrobe),
    .hsDone     (hsDone),
    .atZero     (atZero),
    .stb        (stb),
    .fpDisable  (fpDisable)
  );

  xfc_datapath #(
    .CNT_W     (CNT_W),
    .LO_W      (LO_W),
    .ZERO_CODE (ZERO_CODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .atZero    (atZero),
    .zeroFlag  (zeroFlag),
    .hsPending (hsPending)
  );

endmodule

// File: tb/sim_xfer_countdown.sv
module sim_xfer_countdown;

  localparam int CLK_PERIOD = 10;
  localparam int ZERO       = 'h00FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic        loadCtl = 1'b0;
  logic        cntEn = 1'b0;
  logic        cntClr = 1'b0;
  logic        xferStrobe = 1'b0;
  logic        hsDone = 1'b0;
  logic        rdAddr = 1'b0;
  logic [15:0] rdData;
  logic        fpDisable;
  logic        zeroFlag;
  logic        hsPending;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference model state
  int mCount, mLo, mHi, mHold;
  bit mFlag, mPend, mPrev, mLd, mAcc;

  xfer_countdown u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .loadCtl(loadCtl), .cntEn(cntEn), .cntClr(cntClr), .xferStrobe(xferStrobe),
    .hsDone(hsDone), .rdAddr(rdAddr), .rdData(rdData), .fpDisable(fpDisable),
    .zeroFlag(zeroFlag), .hsPending(hsPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mCount = ZERO; mFlag = 0; mPend = 0; mPrev = 0; mLo = 0; mHi = 0;
    end else begin
      mHold = mHi * 65536 + mLo;
      mLd   = loadCtl && !mPrev;
      mPrev = loadCtl;
      mAcc  = xferStrobe && !(cntEn && mCount <= ZERO);
      if (cntClr) begin
        mCount = ZERO; mFlag = 0; mPend = 0;
      end else begin
        if (mLd) begin
          mCount = mHold; mFlag = (mHold <= ZERO);
        end else if (cntEn && xferStrobe && mCount > ZERO) begin
          mCount = mCount - 1;
          if (mCount == ZERO) mFlag = 1;
        end
        if (mAcc) mPend = 1;
        else if (hsDone) mPend = 0;
      end
      if (wrEn) begin
        if (!wrAddr) mLo = int'(wrData);
        else         mHi = int'(wrData[7:0]);
      end
    end
  end

  // Compare every cycle, half a period after the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R5", "fpDisable", fpDisable, (cntEn && mCount <= ZERO));
      check("R7", "zeroFlag", zeroFlag, mFlag);
      check("R9", "hsPending", hsPending, mPend);
      check("R10", "rdData", rdData,
            rdAddr ? ((mCount >> 16) & 'hFF) : (mCount & 'hFFFF));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chkRead(input string tag, input logic a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    check(tag, a ? "rdData hi" : "rdData lo", rdData, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    chkRead("R1", 1'b0, 16'hFFFF);
    chkRead("R1", 1'b1, 16'h0000);
    check("R1", "zeroFlag", zeroFlag, 0);
    check("R1", "hsPending", hsPending, 0);

    // R2: holding writes leave the count alone
    wrEn = 1; wrAddr = 0; wrData = 16'h0001; tick();
    wrAddr = 1; wrData = 16'hAB01; tick();
    wrEn = 0; tick();
    chkRead("R2", 1'b0, 16'hFFFF);

    // R3: edge load of 0x010001, then no reload on level
    loadCtl = 1; tick(); tick();
    chkRead("R3", 1'b0, 16'h0001);
    chkRead("R3", 1'b1, 16'h0001);
    wrEn = 1; wrAddr = 0; wrData = 16'h0005; tick();
    wrEn = 0; tick(); tick();
    chkRead("R3", 1'b0, 16'h0001);

    // R4: count down across the borrow to the zero code
    cntEn = 1; xferStrobe = 1; tick();
    chkRead("R4", 1'b0, 16'h0000);
    chkRead("R4", 1'b1, 16'h0001);
    tick();
    chkRead("R4", 1'b0, 16'hFFFF);
    chkRead("R4", 1'b1, 16'h0000);
    check("R7", "zeroFlag at zero", zeroFlag, 1);
    check("R5", "fpDisable at zero", fpDisable, 1);
    tick(); tick();
    chkRead("R5", 1'b0, 16'hFFFF);
    xferStrobe = 0; tick(); tick();
    check("R7", "zeroFlag held", zeroFlag, 1);
    check("R9", "hsPending open", hsPending, 1);
    hsDone = 1; tick(); hsDone = 0;
    check("R9", "hsPending closed", hsPending, 0);

    // R6: disabled counter loaded with 0x010005 ignores strobes
    loadCtl = 0; tick();
    loadCtl = 1; cntEn = 0; tick(); tick();
    check("R7", "zeroFlag after nonzero load", zeroFlag, 0);
    xferStrobe = 1; tick(); tick(); xferStrobe = 0;
    chkRead("R6", 1'b0, 16'h0005);
    check("R6", "fpDisable off", fpDisable, 0);
    check("R9", "hsPending from unblocked strobe", hsPending, 1);

    // R8: clear beats a simultaneous load edge
    loadCtl = 0; tick();
    loadCtl = 1; cntClr = 1; tick(); cntClr = 0; tick();
    chkRead("R8", 1'b0, 16'hFFFF);
    check("R8", "zeroFlag", zeroFlag, 0);
    check("R8", "hsPending", hsPending, 0);

    // Random phase, model compared every cycle
    cntEn = 1;
    for (int i = 0; i < 6000; i++) begin
      wrEn       = ($urandom_range(0, 3) == 0);
      wrAddr     = $urandom_range(0, 1);
      wrData     = wrAddr ? 16'($urandom_range(0, 7) == 0 ? 'hFF : $urandom_range(0, 1))
                          : (($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 12))
                                                         : 16'($urandom));
      if ($urandom_range(0, 7) == 0) loadCtl = ~loadCtl;
      cntClr     = ($urandom_range(0, 63) == 0);
      cntEn      = ($urandom_range(0, 15) != 0);
      xferStrobe = $urandom_range(0, 1);
      hsDone     = ($urandom_range(0, 3) == 0);
      rdAddr     = $urandom_range(0, 1);
      tick();
    end

    // R7: load of exactly the zero code sets the flag
    wrEn = 1; wrAddr = 1; wrData = 16'h0000; xferStrobe = 0; cntClr = 0; loadCtl = 0; tick();
    wrAddr = 0; wrData = 16'hFFFF; tick();
    wrEn = 0; loadCtl = 1; tick(); tick();
    check("R7", "zeroFlag on zero-code load", zeroFlag, 1);

    finishRun();
  end

endmodule